// File: doc/BRIEF.md
# Ping-Pong Transmit Descriptor DMA

This block moves transmit data for one serial channel from memory into a byte-wide transmit FIFO. It works from two buffer descriptors, A and B. Each descriptor holds a buffer address, a byte count and a status byte. An ownership bit in the status byte hands each descriptor back and forth between the CPU and the engine. The CPU fills a descriptor and sets its ownership bit. The engine then reads the buffer one byte at a time, pushes each byte into the FIFO and clears the ownership bit. After that it moves on to the other descriptor, so the two alternate strictly.

Buffers can be chained into one frame. A buffer without its end-of-frame bit continues the current frame. The framer receives a CRC-append strobe only when a buffer that has end-of-frame set is released. A buffer-done interrupt pulses when a buffer is released, which happens after its last byte has entered the FIFO. Each buffer can enable or suppress this interrupt through its own status bit. A transmit-empty interrupt reports that the engine is waiting on a descriptor it does not own.

Top module: `tx_desc_dma`

## Requirements
- R1: The block holds two descriptors. `cpu_sel_i` selects the descriptor (0 = A, 1 = B) and `cpu_reg_i` selects the register (0 = 32-bit address, 1 = 16-bit count, 2 = 8-bit status). A write while the descriptor is CPU-owned stores the data. The status bytes read back on `sts_a_o` and `sts_b_o`. Status bit 7 is ownership, bit 6 is end-of-frame and bit 5 is the per-buffer interrupt enable.
- R2: While a descriptor's ownership bit is set, CPU writes to any of its three registers are ignored.
- R3: With `en_i` high, the engine first waits for descriptor A to be owned and then services descriptors in the order A, B, A, B. Releasing a descriptor clears its ownership bit.
- R4: `next_buf_o` names the descriptor that the engine services next (0 = A, 1 = B). It toggles on each release.
- R5: The engine has at most one byte read outstanding. `mem_req_o` and `mem_addr_o` are held until `mem_rvalid_i`. Addresses run upward from the descriptor address, and the bytes enter the FIFO in that order.
- R6: No byte is written into the FIFO while `fifo_full_i` is high. The engine stalls until it drops.
- R7: `done_irq_o` pulses on the release of a buffer only when both that buffer's interrupt-enable bit and `txd_ie_i` are set. The release comes after the buffer's last byte has been written into the FIFO and before any byte of the next buffer.
- R8: `crc_req_o` pulses only on the release of a buffer whose end-of-frame bit is set. Buffers without that bit chain into the same frame with no strobe.
- R9: `done_eof_o` pulses together with `done_irq_o` when the released buffer has end-of-frame set, and at no other time.
- R10: `empty_irq_o` is high exactly when `en_i` and `txe_ie_i` are high and the engine is waiting on a descriptor it does not own. It stays low while a buffer is being transferred.
- R11: A descriptor with a count of zero is released without any memory read or FIFO write. Its end-of-frame and interrupt bits still take effect.
- R12: Dropping `en_i` sends the engine back to waiting on descriptor A (`next_buf_o` = 0) and leaves every ownership bit as it was. On re-enable, an owned descriptor is transferred again from its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable in DMA mode |
| txd_ie_i | input | 1 | Global buffer-done interrupt enable |
| txe_ie_i | input | 1 | Transmit-empty interrupt enable |
| cpu_we_i | input | 1 | Descriptor register write strobe |
| cpu_sel_i | input | 1 | Descriptor select, 0 = A, 1 = B |
| cpu_reg_i | input | 2 | Register select: 0 address, 1 count, 2 status |
| cpu_wdata_i | input | 32 | Write data |
| sts_a_o | output | 8 | Status byte of descriptor A |
| sts_b_o | output | 8 | Status byte of descriptor B |
| next_buf_o | output | 1 | Descriptor serviced next |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | 32 | Byte read address |
| mem_rvalid_i | input | 1 | Read data valid, completes the request |
| mem_rdata_i | input | 8 | Read data |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 8 | FIFO write byte |
| fifo_full_i | input | 1 | FIFO full |
| crc_req_o | output | 1 | CRC-append strobe to the framer |
| done_irq_o | output | 1 | Buffer-done interrupt pulse |
| done_eof_o | output | 1 | End-of-frame flag of the buffer-done interrupt |
| empty_irq_o | output | 1 | Transmit-empty interrupt |

## Verification
The bench builds the block with its default 32-bit address and 16-bit count parameters. A buffer starting at 0x1FE is used so that the byte address carries from the low byte into the next byte, and the bench memory returns a byte derived from both address bytes. Read latency and FIFO back-pressure vary from cycle to cycle. Those defaults bring within reach chained frames, zero-length buffers, writes to owned descriptors and a disable in the middle of a transfer while the other descriptor stays owned.

// File: rtl/tx_desc_pkg.sv
package tx_desc_pkg;
  localparam int STS_W   = 8;
  localparam int OWN_BIT = 7;
  localparam int EOF_BIT = 6;
  localparam int IE_BIT  = 5;

  typedef enum logic [1:0] {
    REG_ADDR = 2'd0,
    REG_CNT  = 2'd1,
    REG_STS  = 2'd2
  } reg_e;

  typedef enum logic [1:0] {
    S_WAIT,
    S_XFER,
    S_PUSH,
    S_REL
  } state_e;
endpackage

// File: rtl/tx_desc_slot.sv
module tx_desc_slot
  import tx_desc_pkg::*;
#(
  parameter int  ADDR_W  = 32,
  parameter int  CNT_W   = 16,
  parameter logic SLOT_ID = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_we_i,
  input  logic              cpu_sel_i,
  input  logic [1:0]        cpu_reg_i,
  input  logic [ADDR_W-1:0] cpu_wdata_i,
  input  logic              clr_own_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [STS_W-1:0]  sts_o
);
  logic hit;
  assign hit = cpu_we_i && (cpu_sel_i == SLOT_ID) && !sts_o[OWN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      cnt_o  <= '0;
      sts_o  <= '0;
    end else if (clr_own_i) begin
      sts_o[OWN_BIT] <= 1'b0;
    end else if (hit) begin
      case (reg_e'(cpu_reg_i))
        REG_ADDR: addr_o <= cpu_wdata_i;
        REG_CNT:  cnt_o  <= cpu_wdata_i[CNT_W-1:0];
        REG_STS:  sts_o  <= cpu_wdata_i[STS_W-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/tx_desc_fetch.sv
module tx_desc_fetch
  import tx_desc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] d_addr_i,
  input  logic [CNT_W-1:0]  d_cnt_i,
  input  logic [STS_W-1:0]  d_sts_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              fifo_wr_o,
  output logic [7:0]        fifo_data_o,
  input  logic              fifo_full_i,
  output logic              rel_o,
  output logic              rel_eof_o,
  output logic              rel_ie_o,
  output logic              cur_o,
  output logic              idle_o
);
  state_e             state_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [7:0]         hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_WAIT;
      cur_o     <= 1'b0;
      addr_q    <= '0;
      cnt_q     <= '0;
      hold_q    <= '0;
      rel_eof_o <= 1'b0;
      rel_ie_o  <= 1'b0;
    end else if (!en_i) begin
      state_q <= S_WAIT;
      cur_o   <= 1'b0;
    end else begin
      case (state_q)
        S_WAIT: if (d_sts_i[OWN_BIT]) begin
          addr_q    <= d_addr_i;
          cnt_q     <= d_cnt_i;
          rel_eof_o <= d_sts_i[EOF_BIT];
          rel_ie_o  <= d_sts_i[IE_BIT];
          state_q   <= S_XFER;
        end
        S_XFER: if (cnt_q == '0) begin
          state_q <= S_REL;
        end else if (mem_rvalid_i) begin
          hold_q  <= mem_rdata_i;
          state_q <= S_PUSH;
        end
        S_PUSH: if (!fifo_full_i) begin
          addr_q  <= addr_q + 1'b1;
          cnt_q   <= cnt_q - 1'b1;
          state_q <= S_XFER;
        end
        S_REL: begin
          cur_o   <= ~cur_o;
          state_q <= S_WAIT;
        end
        default: state_q <= S_WAIT;
      endcase
    end
  end

  assign mem_req_o   = en_i && (state_q == S_XFER) && (cnt_q != '0);
  assign mem_addr_o  = addr_q;
  assign fifo_wr_o   = en_i && (state_q == S_PUSH) && !fifo_full_i;
  assign fifo_data_o = hold_q;
  assign rel_o       = en_i && (state_q == S_REL);
  assign idle_o      = (state_q == S_WAIT);
endmodule

// File: rtl/tx_desc_irq.sv
module tx_desc_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic txd_ie_i,
  input  logic txe_ie_i,
  input  logic rel_i,
  input  logic rel_eof_i,
  input  logic rel_ie_i,
  input  logic idle_i,
  input  logic own_cur_i,
  output logic crc_req_o,
  output logic done_irq_o,
  output logic done_eof_o,
  output logic empty_irq_o
);
  logic fire;
  assign fire = rel_i && rel_ie_i && txd_ie_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_req_o  <= 1'b0;
      done_irq_o <= 1'b0;
      done_eof_o <= 1'b0;
    end else begin
      crc_req_o  <= rel_i && rel_eof_i;
      done_irq_o <= fire;
      done_eof_o <= fire && rel_eof_i;
    end
  end

  assign empty_irq_o = en_i && txe_ie_i && idle_i && !own_cur_i;
endmodule

// File: rtl/tx_desc_dma.sv
module tx_desc_dma
  import tx_desc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              txd_ie_i,
  input  logic              txe_ie_i,
  input  logic              cpu_we_i,
  input  logic              cpu_sel_i,
  input  logic [1:0]        cpu_reg_i,
  input  logic [ADDR_W-1:0] cpu_wdata_i,
  output logic [STS_W-1:0]  sts_a_o,
  output logic [STS_W-1:0]  sts_b_o,
  output logic              next_buf_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              fifo_wr_o,
  output logic [7:0]        fifo_data_o,
  input  logic              fifo_full_i,
  output logic              crc_req_o,
  output logic              done_irq_o,
  output logic              done_eof_o,
  output logic              empty_irq_o
);
  localparam int N_SLOT = 2;

  logic [ADDR_W-1:0] d_addr [N_SLOT];
  logic [CNT_W-1:0]  d_cnt  [N_SLOT];
  logic [STS_W-1:0]  d_sts  [N_SLOT];
  logic rel, rel_eof, rel_ie, cur, idle;

  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    tx_desc_slot #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .SLOT_ID(1'(i))
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cpu_we_i   (cpu_we_i),
      .cpu_sel_i  (cpu_sel_i),
      .cpu_reg_i  (cpu_reg_i),
      .cpu_wdata_i(cpu_wdata_i),
      .clr_own_i  (rel && (cur == 1'(i))),
      .addr_o     (d_addr[i]),
      .cnt_o      (d_cnt[i]),
      .sts_o      (d_sts[i])
    );
  end

  tx_desc_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .d_addr_i    (d_addr[cur]),
    .d_cnt_i     (d_cnt[cur]),
    .d_sts_i     (d_sts[cur]),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i (mem_rdata_i),
    .fifo_wr_o   (fifo_wr_o),
    .fifo_data_o (fifo_data_o),
    .fifo_full_i (fifo_full_i),
    .rel_o       (rel),
    .rel_eof_o   (rel_eof),
    .rel_ie_o    (rel_ie),
    .cur_o       (cur),
    .idle_o      (idle)
  );

  tx_desc_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .txd_ie_i   (txd_ie_i),
    .txe_ie_i   (txe_ie_i),
    .rel_i      (rel),
    .rel_eof_i  (rel_eof),
    .rel_ie_i   (rel_ie),
    .idle_i     (idle),
    .own_cur_i  (d_sts[cur][OWN_BIT]),
    .crc_req_o  (crc_req_o),
    .done_irq_o (done_irq_o),
    .done_eof_o (done_eof_o),
    .empty_irq_o(empty_irq_o)
  );

  assign sts_a_o    = d_sts[0];
  assign sts_b_o    = d_sts[1];
  assign next_buf_o = cur;
endmodule

// File: rtl/tx_desc_dma_chk.sv
module tx_desc_dma_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              txd_ie_i,
  input logic              txe_ie_i,
  input logic              cpu_we_i,
  input logic              cpu_sel_i,
  input logic [7:0]        sts_a_o,
  input logic [7:0]        sts_b_o,
  input logic              next_buf_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rvalid_i,
  input logic              fifo_wr_o,
  input logic              fifo_full_i,
  input logic              crc_req_o,
  input logic              done_irq_o,
  input logic              done_eof_o,
  input logic              empty_irq_o
);
  assert_owned_a_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_a_o[7] && cpu_we_i && !cpu_sel_i) |=> (sts_a_o[6:0] == $past(sts_a_o[6:0])));
  assert_owned_b_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_b_o[7] && cpu_we_i && cpu_sel_i) |=> (sts_b_o[6:0] == $past(sts_b_o[6:0])));
  assert_release_clears_own_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && (next_buf_o != $past(next_buf_o)))
      |-> ($past(next_buf_o) ? !sts_b_o[7] : !sts_a_o[7]));
  assert_req_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i && en_i)
      |=> (!en_i || (mem_req_o && (mem_addr_o == $past(mem_addr_o)))));
  assert_no_push_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> !fifo_full_i);
  assert_done_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |-> $past(txd_ie_i));
  assert_crc_at_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_req_o |-> (next_buf_o != $past(next_buf_o)));
  assert_eof_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_eof_o |-> (done_irq_o && crc_req_o));
  assert_empty_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_irq_o |-> (txe_ie_i && en_i && !mem_req_o && !fifo_wr_o));
endmodule

bind tx_desc_dma tx_desc_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .txd_ie_i    (txd_ie_i),
  .txe_ie_i    (txe_ie_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_sel_i   (cpu_sel_i),
  .sts_a_o     (sts_a_o),
  .sts_b_o     (sts_b_o),
  .next_buf_o  (next_buf_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rvalid_i(mem_rvalid_i),
  .fifo_wr_o   (fifo_wr_o),
  .fifo_full_i (fifo_full_i),
  .crc_req_o   (crc_req_o),
  .done_irq_o  (done_irq_o),
  .done_eof_o  (done_eof_o),
  .empty_irq_o (empty_irq_o)
);

// File: tb/tx_desc_dma_bench.sv
module tx_desc_dma_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, txd_ie = 1'b1, txe_ie = 1'b0;
  logic cpu_we = 1'b0, cpu_sel = 1'b0;
  logic [1:0] cpu_reg = '0;
  logic [31:0] cpu_wdata = '0;
  logic [7:0] sts_a, sts_b, mem_rdata = '0, fifo_data;
  logic next_buf, mem_req, mem_rvalid = 1'b0, fifo_wr, fifo_full = 1'b0;
  logic [31:0] mem_addr;
  logic crc_req, done_irq, done_eof, empty_irq;

  int tests = 0, fails = 0, full_mode = 0;
  int exp_q[$];
  bit prev_nb = 1'b0, ended = 1'b0;

  tx_desc_dma u_tx_desc_dma (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .txd_ie_i(txd_ie), .txe_ie_i(txe_ie),
    .cpu_we_i(cpu_we), .cpu_sel_i(cpu_sel), .cpu_reg_i(cpu_reg), .cpu_wdata_i(cpu_wdata),
    .sts_a_o(sts_a), .sts_b_o(sts_b), .next_buf_o(next_buf),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .fifo_wr_o(fifo_wr), .fifo_data_o(fifo_data), .fifo_full_i(fifo_full),
    .crc_req_o(crc_req), .done_irq_o(done_irq), .done_eof_o(done_eof), .empty_irq_o(empty_irq)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [1:0] r, input logic [31:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_sel = sel; cpu_reg = r; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic push_model(input logic [31:0] a, input int n, input bit eof, input bit ie);
    for (int i = 0; i < n; i++) exp_q.push_back(int'(mem_byte(a + 32'(i))));
    exp_q.push_back(1000 + (eof ? 2 : 0) + ((ie && txd_ie) ? 1 : 0));
  endtask

  // fill a CPU-owned descriptor, check readback (R1), hand it to the engine
  task automatic load(input bit sel, input logic [31:0] a, input int n, input bit eof, input bit ie);
    logic [7:0] s;
    s = {1'b0, eof, ie, 5'h0};
    wr(sel, 2'd0, a);
    wr(sel, 2'd1, 32'(n));
    wr(sel, 2'd2, 32'(s));
    chk((sel ? sts_b : sts_a) == s, "R1 status readback", sel ? sts_b : sts_a, s);
    push_model(a, n, eof, ie);
    wr(sel, 2'd2, 32'(s | 8'h80));
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
    cyc(4);
    chk(exp_q.size() == 0, "R3 all expected events seen", exp_q.size(), 0);
  endtask

  // memory and FIFO back-pressure stimulus
  initial forever begin
    @(negedge clk);
    mem_rvalid = mem_req && ($urandom % 3 != 0);
    mem_rdata  = mem_byte(mem_addr);
    fifo_full  = (full_mode == 2) ? 1'b1 : (full_mode == 1) ? ($urandom % 4 == 0) : 1'b0;
  end

  // cycle-by-cycle comparison against the expected event queue
  initial forever begin
    int e;
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n) begin
      if (fifo_wr) begin
        if (fifo_full) chk(1'b0, "R6 write while full", 1, 0);
        if (exp_q.size() == 0 || exp_q[0] >= 1000) chk(1'b0, "R5 unexpected byte", fifo_data, -1);
        else begin
          e = exp_q.pop_front();
          chk(fifo_data == 8'(e), "R5 byte data/order", fifo_data, e);
        end
      end
      if (en && next_buf != prev_nb) begin
        if (exp_q.size() == 0 || exp_q[0] < 1000) chk(1'b0, "R7 release before last byte", next_buf, prev_nb);
        else begin
          e = exp_q.pop_front() - 1000;
          chk(crc_req == e[1], "R8 crc strobe at release", crc_req, e[1]);
          chk(done_irq == e[0], "R7 done irq at release", done_irq, e[0]);
          chk(done_eof == (e[0] && e[1]), "R9 eof flag", done_eof, e[0] && e[1]);
          chk(!(prev_nb ? sts_b[7] : sts_a[7]), "R3 own cleared on release", 1, 0);
        end
      end else if (crc_req || done_irq || done_eof) begin
        chk(1'b0, "R8 R9 pulse without release", {crc_req, done_irq, done_eof}, 0);
      end
      prev_nb = next_buf;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk(next_buf == 1'b0 && sts_a == 0 && sts_b == 0, "R4 reset state", {next_buf, sts_a, sts_b}, 0);
    chk(!mem_req && !fifo_wr && !empty_irq && !crc_req && !done_irq, "R10 reset outputs quiet", 1, 0);

    en = 1'b1; txe_ie = 1'b1;
    cyc(2);
    chk(empty_irq == 1'b1, "R10 empty when nothing owned", empty_irq, 1);

    // single buffer on A with eof and irq
    full_mode = 1;
    load(1'b0, 32'h0000_0100, 5, 1'b1, 1'b1);
    drain();
    chk(next_buf == 1'b1, "R4 next buffer is B", next_buf, 1);

    // chained frame: B without eof, then A closing the frame
    load(1'b1, 32'h0000_0200, 3, 1'b0, 1'b0);
    load(1'b0, 32'h0000_0300, 4, 1'b1, 1'b1);
    drain();

    // writes to an owned descriptor are ignored (R2)
    full_mode = 2;
    load(1'b1, 32'h0000_01FE, 4, 1'b1, 1'b1);
    cyc(6);
    chk(empty_irq == 1'b0, "R10 no empty while transferring", empty_irq, 0);
    chk(mem_req == 1'b0, "R6 stalled on full, no second read", mem_req, 0);
    wr(1'b1, 2'd0, 32'h0000_5000);
    wr(1'b1, 2'd1, 32'd0);
    wr(1'b1, 2'd2, 32'd0);
    chk(sts_b == 8'hE0, "R2 owned status unchanged", sts_b, 8'hE0);
    load(1'b0, 32'h0000_0400, 2, 1'b0, 1'b1);
    full_mode = 1;
    drain();

    // zero-length buffer still releases with eof and irq
    load(1'b1, 32'h0000_0500, 0, 1'b1, 1'b1);
    drain();
    chk(next_buf == 1'b0, "R11 zero count released", next_buf, 0);

    // global enable off suppresses buffer-done
    txd_ie = 1'b0;
    load(1'b0, 32'h0000_0600, 2, 1'b1, 1'b1);
    drain();
    txd_ie = 1'b1;

    // disable mid-transfer on B
    full_mode = 2;
    load(1'b1, 32'h0000_0700, 6, 1'b1, 1'b1);
    cyc(8);
    en = 1'b0;
    exp_q.delete();
    cyc(2);
    chk(next_buf == 1'b0, "R12 disable returns to A", next_buf, 0);
    chk(sts_b[7] == 1'b1, "R12 ownership kept", sts_b[7], 1);
    en = 1'b1;
    cyc(3);
    chk(empty_irq == 1'b1, "R10 waiting on unowned A", empty_irq, 1);
    load(1'b0, 32'h0000_0800, 2, 1'b0, 1'b0);
    push_model(32'h0000_0700, 6, 1'b1, 1'b1);
    full_mode = 1;
    drain();
    chk(empty_irq == 1'b1, "R10 empty after all released", empty_irq, 1);

    finish_up();
  end
endmodule